// File: doc/BRIEF.md
# Floating-point exception status recorder

This block sits at the retirement point of a floating-point pipeline. When an operation finishes, the datapath raises a one-cycle valid strobe with a 5-bit vector of the IEEE exceptions that the operation produced. The recorder compares that vector against the trap-enable mask held in its status register. It then updates the status register's current and accrued exception fields and decides whether a trap is taken.

If no trap is taken, the recorder retires the instruction by stepping its program-counter pair. If a trap is taken, it keeps the counters where they are, marks the trap type in the status register and pulses a trap line. When several enabled exceptions occur together, only one of them is reported, chosen by a fixed priority. Software reads and writes the whole status word through a simple register port.

The flag vector uses these bit positions: invalid = bit 4, overflow = bit 3, underflow = bit 2, divide-by-zero = bit 1, inexact = bit 0. The status word holds the trap-enable mask at bits 27:23, the accrued field at bits 9:5 and the current field at bits 4:0, with the same bit order inside each field. Bit 14 marks an IEEE-exception trap.

Top module: `fp_exc_recorder`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0, pc reads RESET_PC, npc reads RESET_PC+4 and trap_o is 0.
- R2: A status write (sr_wr_en high, flag_vld low) loads the whole word, and it reads back on sr_rd_data from the next cycle.
- R3: An event (flag_vld high) takes a trap exactly when flag_vec AND the enable mask (status bits 27:23) is nonzero. trap_o is high for exactly the one cycle after the event's clock edge.
- R4: On a trap, the flags are masked to the enabled ones, and only the highest-priority survivor is kept. The priority order is invalid (bit 4), overflow (3), underflow (2), divide-by-zero (1), inexact (0).
- R5: Every event replaces the current field (status bits 4:0) with the resulting vector. That vector is the single kept flag on a trap and the raw flag_vec otherwise, so an event with no flags clears the field.
- R6: The resulting vector is ORed into the accrued field (status bits 9:5) only when no trap is taken. On a trap the accrued field is unchanged.
- R7: A trap sets status bit 14. No event alters any status bit outside bits 9:0 and bit 14.
- R8: An event without a trap moves pc to the old npc and advances npc by 4. An event with a trap leaves pc and npc unchanged.
- R9: While flag_vld is low, flag_vec has no effect on the status word, the counters or trap_o.
- R10: A status write in the same cycle as an event is dropped. The event is evaluated against the status word held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_vld | input | 1 | Operation-complete strobe |
| flag_vec | input | 5 | Raised exception flags of the completed operation |
| sr_wr_en | input | 1 | Status word write enable |
| sr_wr_data | input | SR_W (32) | Status word write value |
| sr_rd_data | output | SR_W (32) | Current status word |
| pc | output | PC_W (32) | Current program counter |
| npc | output | PC_W (32) | Next program counter |
| trap_o | output | 1 | One-cycle pulse when an IEEE trap is taken |

## Verification
The bench targets events where several enabled flags coincide. A design with a wrong priority chain would report two bits, or the wrong single bit, in the current field. It also covers events whose raised flags are all disabled, where a design that only looked at the raw flags would trap wrongly. Trapping events are checked to confirm that the accrued field and the counters stay frozen; a design that ORs in or advances regardless would corrupt them. Further cases cover a zero-flag event that must still clear stale current bits, a status write colliding with an event, back-to-back events, and flags driven while the strobe is low, which a careless design would absorb.

// File: rtl/fpx_pkg.sv
// Package: field positions of the floating-point status word and flag order.
// Assumes a status word of at least 28 bits.
package fpx_pkg;
    localparam int FLAG_W   = 5;   // exception flag count
    localparam int TEM_LSB  = 23;  // trap-enable mask field
    localparam int AEXC_LSB = 5;   // accrued field
    localparam int CEXC_LSB = 0;   // current field
    localparam int TT_BIT   = 14;  // trap-type bit set on IEEE trap
    localparam int FLG_NV   = 4;   // invalid, highest priority
    localparam int FLG_OF   = 3;
    localparam int FLG_UF   = 2;
    localparam int FLG_DZ   = 1;
    localparam int FLG_NX   = 0;   // inexact, lowest priority
endpackage

// File: rtl/fpx_trap_decide.sv
// Combinational trap decision: masks raised flags with the enables and, on a
// trap, keeps only the highest set bit (MSB = highest priority).
// Assumes flag bit order matches priority order.
module fpx_trap_decide #(
    parameter int W = 5
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] enables,
    output logic         take_trap,
    output logic [W-1:0] result
);
    logic [W-1:0] masked;
    logic [W:0]   above;   // above[i]: some masked bit at index >= i
    logic [W-1:0] pick;

    assign masked   = flags & enables;
    assign above[W] = 1'b0;

    // Priority chain: a bit survives only if no higher masked bit is set.
    for (genvar i = W - 1; i >= 0; i--) begin : g_prio
        assign above[i] = above[i+1] | masked[i];
        assign pick[i]  = masked[i] & ~above[i+1];
    end

    // Select the single survivor on a trap, the raw flags otherwise.
    always_comb begin
        take_trap = |masked;
        result    = take_trap ? pick : flags;
    end
endmodule

// File: rtl/fpx_status_reg.sv
// Status word register: software write port plus event update of the
// current/accrued fields and the trap-type bit. An event wins over a write.
module fpx_status_reg
    import fpx_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_vld,
    input  logic              take_trap,
    input  logic [FLAG_W-1:0] result,
    input  logic              wr_en,
    input  logic [SR_W-1:0]   wr_data,
    output logic [SR_W-1:0]   status_q
);
    logic [SR_W-1:0] evt_next;

    // Event update of the status word.
    always_comb begin
        evt_next = status_q;
        evt_next[CEXC_LSB +: FLAG_W] = result;
        if (take_trap)
            evt_next[TT_BIT] = 1'b1;
        else
            evt_next[AEXC_LSB +: FLAG_W] = status_q[AEXC_LSB +: FLAG_W] | result;
    end

    // Register with reset; an event takes precedence over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (evt_vld)
            status_q <= evt_next;
        else if (wr_en)
            status_q <= wr_data;
    end
endmodule

// File: rtl/fpx_pc_seq.sv
// Program-counter pair: on advance, pc takes npc and npc steps forward.
module fpx_pc_seq #(
    parameter int              PC_W     = 32,
    parameter int              PC_STEP  = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] npc
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    // Reset to the start pair, step on advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= RESET_PC;
            npc <= RESET_PC + STEP_V;
        end else if (advance) begin
            pc  <= npc;
            npc <= npc + STEP_V;
        end
    end
endmodule

// File: rtl/fp_exc_recorder.sv
// Top: records the outcome of a finished FP operation. Decides trap/no-trap
// from the enable mask, updates the status word, steps the pc pair when no
// trap, and pulses trap_o one cycle after a trapping event.
module fp_exc_recorder
    import fpx_pkg::*;
#(
    parameter int              SR_W     = 32,
    parameter int              PC_W     = 32,
    parameter int              PC_STEP  = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_vld,
    input  logic [FLAG_W-1:0] flag_vec,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    output logic [SR_W-1:0]   sr_rd_data,
    output logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   npc,
    output logic              trap_o
);
    logic              take_trap;
    logic [FLAG_W-1:0] result;
    logic [SR_W-1:0]   status_q;

    fpx_trap_decide #(.W(FLAG_W)) u_decide (
        .flags     (flag_vec),
        .enables   (status_q[TEM_LSB +: FLAG_W]),
        .take_trap (take_trap),
        .result    (result)
    );

    fpx_status_reg #(.SR_W(SR_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_vld   (flag_vld),
        .take_trap (take_trap),
        .result    (result),
        .wr_en     (sr_wr_en),
        .wr_data   (sr_wr_data),
        .status_q  (status_q)
    );

    fpx_pc_seq #(.PC_W(PC_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (flag_vld & ~take_trap),
        .pc      (pc),
        .npc     (npc)
    );

    // One-cycle trap pulse registered from the event edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trap_o <= 1'b0;
        else
            trap_o <= flag_vld & take_trap;
    end

    assign sr_rd_data = status_q;
endmodule

// File: rtl/fpx_recorder_chk.sv
// Checker for fp_exc_recorder, attached by bind. Relates ports across cycles.
module fpx_recorder_chk
    import fpx_pkg::*;
#(
    parameter int SR_W    = 32,
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_vld,
    input logic [FLAG_W-1:0] flag_vec,
    input logic [SR_W-1:0]   sr_rd_data,
    input logic [PC_W-1:0]   pc,
    input logic [PC_W-1:0]   npc,
    input logic              trap_o
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    AST_TRAP_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ($past(flag_vld) &&
                    (($past(flag_vec) & $past(sr_rd_data[TEM_LSB +: FLAG_W])) != '0))); // R3
    AST_TRAP_SINGLE_CEXC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ($countones(sr_rd_data[CEXC_LSB +: FLAG_W]) == 1)); // R4
    AST_AEXC_FROZEN_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (sr_rd_data[AEXC_LSB +: FLAG_W] == $past(sr_rd_data[AEXC_LSB +: FLAG_W]))); // R6
    AST_TT_SET_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> sr_rd_data[TT_BIT]); // R7
    AST_PC_HELD_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ($stable(pc) && $stable(npc))); // R8
    AST_PC_STEP_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_vld) && !trap_o) |->
            (pc == $past(npc) && npc == $past(npc) + STEP_V)); // R8
    AST_IDLE_PC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flag_vld)) |-> ($stable(pc) && $stable(npc) && !trap_o)); // R9
endmodule

bind fp_exc_recorder fpx_recorder_chk #(
    .SR_W(SR_W), .PC_W(PC_W), .PC_STEP(PC_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_vld(flag_vld), .flag_vec(flag_vec),
    .sr_rd_data(sr_rd_data), .pc(pc), .npc(npc), .trap_o(trap_o)
);

// File: tb/fp_exc_recorder_test.sv
module fp_exc_recorder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_vld = 1'b0;
    logic [4:0]  flag_vec = '0;
    logic        sr_wr_en = 1'b0;
    logic [31:0] sr_wr_data = '0;
    logic [31:0] sr_rd_data;
    logic [31:0] pc, npc;
    logic        trap_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_pc, exp_npc;

    always #2.5 clk = ~clk;

    fp_exc_recorder uut (
        .clk(clk), .rst_n(rst_n), .flag_vld(flag_vld), .flag_vec(flag_vec),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
        .pc(pc), .npc(npc), .trap_o(trap_o)
    );

    // {enables, accrued_init, flags, exp_current, exp_accrued, exp_trap}
    localparam logic [25:0] VEC [10] = '{
        {5'b00000, 5'b00000, 5'b00001, 5'b00001, 5'b00001, 1'b0},
        {5'b00000, 5'b00100, 5'b01001, 5'b01001, 5'b01101, 1'b0},
        {5'b10000, 5'b00000, 5'b10001, 5'b10000, 5'b00000, 1'b1},
        {5'b11111, 5'b00010, 5'b11111, 5'b10000, 5'b00010, 1'b1},
        {5'b01111, 5'b00000, 5'b01101, 5'b01000, 5'b00000, 1'b1},
        {5'b00111, 5'b00000, 5'b00110, 5'b00100, 5'b00000, 1'b1},
        {5'b00011, 5'b00000, 5'b00011, 5'b00010, 5'b00000, 1'b1},
        {5'b00001, 5'b00000, 5'b10000, 5'b10000, 5'b10000, 1'b0},
        {5'b11111, 5'b11111, 5'b00000, 5'b00000, 5'b11111, 1'b0},
        {5'b00100, 5'b00001, 5'b10101, 5'b00100, 5'b00001, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_sr(input logic [31:0] v);
        @(negedge clk); sr_wr_en = 1'b1; sr_wr_data = v;
        @(negedge clk); sr_wr_en = 1'b0;
    endtask

    task automatic fire(input logic [4:0] f);
        @(negedge clk); flag_vld = 1'b1; flag_vec = f;
        @(negedge clk); flag_vld = 1'b0; flag_vec = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", sr_rd_data, 32'h0);
        check("R1 pc", pc, 32'h0);
        check("R1 npc", npc, 32'h4);
        check("R1 trap", {31'b0, trap_o}, 32'h0);
        exp_pc = 32'h0; exp_npc = 32'h4;

        // R2 write/readback
        write_sr(32'h1234_5678);
        check("R2 readback", sr_rd_data, 32'h1234_5678);

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 10; i++) begin
            logic [4:0]  en, ai, fl, ec, ea;
            logic        et;
            logic [31:0] exp_sr;
            {en, ai, fl, ec, ea, et} = VEC[i];
            write_sr((32'(en) << 23) | (32'h1 << 30) | (32'(ai) << 5) | 32'h1F);
            fire(fl);
            exp_sr = (32'(en) << 23) | (32'h1 << 30) | (32'(ea) << 5) | 32'(ec)
                     | (et ? (32'h1 << 14) : 32'h0);
            if (!et) begin exp_pc = exp_npc; exp_npc = exp_npc + 4; end
            check("R3 trap pulse", {31'b0, trap_o}, {31'b0, et});
            check("R4/R5 current", {27'b0, sr_rd_data[4:0]}, {27'b0, ec});
            check("R6 accrued", {27'b0, sr_rd_data[9:5]}, {27'b0, ea});
            check("R7 word", sr_rd_data, exp_sr);
            check("R8 pc", pc, exp_pc);
            check("R8 npc", npc, exp_npc);
            @(negedge clk);
            check("R3 pulse one cycle", {31'b0, trap_o}, 32'h0);
        end

        // R9 flags without strobe
        write_sr(32'h0F80_0000);
        @(negedge clk); flag_vec = 5'b11111;
        repeat (3) @(negedge clk);
        check("R9 status", sr_rd_data, 32'h0F80_0000);
        check("R9 pc", pc, exp_pc);
        check("R9 trap", {31'b0, trap_o}, 32'h0);
        flag_vec = '0;

        // R10 write colliding with event
        write_sr(32'h0);
        @(negedge clk);
        flag_vld = 1'b1; flag_vec = 5'b00001;
        sr_wr_en = 1'b1; sr_wr_data = 32'h0F80_0000;
        @(negedge clk);
        flag_vld = 1'b0; flag_vec = '0; sr_wr_en = 1'b0;
        exp_pc = exp_npc; exp_npc = exp_npc + 4;
        check("R10 write dropped", sr_rd_data, 32'h0000_0021);
        check("R10 no trap", {31'b0, trap_o}, 32'h0);
        check("R10 pc", pc, exp_pc);

        // R6 R8 back-to-back events
        write_sr(32'h0);
        @(negedge clk); flag_vld = 1'b1; flag_vec = 5'b00010;
        @(negedge clk); flag_vec = 5'b00100;
        @(negedge clk); flag_vld = 1'b0; flag_vec = '0;
        exp_pc = exp_npc + 4; exp_npc = exp_npc + 8;
        check("R6 back-to-back", sr_rd_data, 32'h0000_00C4);
        check("R8 back-to-back pc", pc, exp_pc);
        check("R8 back-to-back npc", npc, exp_npc);

        // R5 zero-flag event clears stale current field
        write_sr(32'h0000_001F);
        fire(5'b00000);
        check("R5 zero flags", sr_rd_data, 32'h0);

        // R1 reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 re-reset pc", pc, 32'h0);
        check("R1 re-reset status", sr_rd_data, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule